// File: doc/BRIEF.md
# PWM Output Channel with Staged Duty

One channel of a pulse-width modulator. The channel is fed by a set of shared timebase units. Each unit supplies a free-running cycle counter and a start-of-period strobe. The channel picks one unit and compares that unit's counter with a 10-bit committed duty value. The output is active while the counter is below the duty.

Software reaches the channel through a byte-wide register window:

- **Duty value.** The upper duty bits are written to a staging register. They join the working duty value only when the low duty byte is next written, so a 10-bit value changes in one step.
- **Commit timing.** A new duty value takes effect at the next start-of-period strobe of the selected timebase. A period is therefore never cut short.
- **Control byte.** One byte holds polarity inversion, clock gating and open-drain drive.
- **Timebase select.** A small field chooses the shared timebase.

The pin side provides a level and an output enable. In open-drain mode these emulate a pull-down-only driver.

Top module: `pwm_chan`

## Requirements
- R1: After reset the channel is gated, the duty value is 0, inversion and open-drain are off, and timebase 0 is selected. Readback gives control = 0x02, duty low = 0x00, duty high = 0x00 and select = 0x00, and the pins show `pwm_o`=0, `pwm_oe_o`=1.
- R2: The register offsets are as follows, and reads return 0 in unused bits:
  - offset 0: duty bits [7:0];
  - offset 1: duty bits [9:8], in wdata bits [1:0];
  - offset 4: control, where bit0 = invert, bit1 = gate and bit2 = open-drain;
  - offset 5: timebase select, in bits [1:0].

  Writes to any other offset change nothing.
- R3: A write to offset 1 only stages the upper duty bits. The working duty changes at the next write to offset 0, which loads {staged high, written low}. Reading offset 1 returns the staged bits.
- R4: While the channel is ungated, the internal level one cycle after a clock edge equals (selected counter < committed duty). A duty of 0 gives a constant inactive output. A duty above the counter's wrap value gives a constant active output.
- R5: While the channel is ungated, the committed duty takes the working duty only at a clock edge where the selected timebase's start-of-period strobe is high. Otherwise it holds.
- R6: The select field chooses which counter/strobe pair drives the comparison. A change takes effect at the next clock edge.
- R7: While gated, the internal level is forced inactive from the next edge on. The committed duty follows the working duty every cycle.
- R8: With invert set, the logical output is the complement of the internal level. With gating, the output therefore rests at 1.
- R9: With open-drain set, `pwm_o` is 0 and `pwm_oe_o` is the complement of the logical output. Otherwise `pwm_oe_o` is 1 and `pwm_o` is the logical output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset within the channel |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| tb_cnt_i | input | 40 | Four shared 10-bit cycle counters, unit k at bits [10k+9:10k] |
| tb_sop_i | input | 4 | Start-of-period strobe per shared timebase |
| pwm_o | output | 1 | Pin drive level |
| pwm_oe_o | output | 1 | Pin output enable |

## Verification
The hardest case to reach is a duty write that lands in mid-period while a different period length is selected. The committed value must hold until the selected unit's strobe arrives, and the old value must finish the period. The stimulus runs four bench timebases with unrelated periods. Random register writes land at arbitrary phases, including switches of the select field and toggles of gating between a duty write and its strobe. A reference model then tracks the working, staged and committed duty values edge by edge.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int OFF_DUTY_LO = 0;
  localparam int OFF_DUTY_HI = 1;
  localparam int OFF_CTRL    = 4;
  localparam int OFF_TBSEL   = 5;

  typedef struct packed {
    logic od_en;     // bit2
    logic clk_gate;  // bit1
    logic pol_inv;   // bit0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{od_en: 1'b0, clk_gate: 1'b1, pol_inv: 1'b0};

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DUTY_W = 10,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DUTY_W-1:0] duty_o,
  output ctrl_t             ctrl_o,
  output logic [SEL_W-1:0]  sel_o
);

  localparam int HI_W = DUTY_W - DATA_W;

  logic [HI_W-1:0]   hi_stage_q;
  logic [DUTY_W-1:0] duty_q;
  ctrl_t             ctrl_q;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_stage_q <= '0;
      duty_q     <= '0;
      ctrl_q     <= CTRL_RST;
      sel_q      <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_W'(OFF_DUTY_LO): duty_q     <= {hi_stage_q, wdata_i};
        ADDR_W'(OFF_DUTY_HI): hi_stage_q <= wdata_i[HI_W-1:0];
        ADDR_W'(OFF_CTRL):    ctrl_q     <= ctrl_t'(wdata_i[2:0]);
        ADDR_W'(OFF_TBSEL):   sel_q      <= wdata_i[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(OFF_DUTY_LO): rdata_o = duty_q[DATA_W-1:0];
      ADDR_W'(OFF_DUTY_HI): rdata_o = DATA_W'(hi_stage_q);
      ADDR_W'(OFF_CTRL):    rdata_o = DATA_W'(ctrl_q);
      ADDR_W'(OFF_TBSEL):   rdata_o = DATA_W'(sel_q);
      default:              rdata_o = '0;
    endcase
  end

  assign duty_o = duty_q;
  assign ctrl_o = ctrl_q;
  assign sel_o  = sel_q;

  // R3
  hi_stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFF_DUTY_HI)) |=> $stable(duty_q));

  // R2
  stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != ADDR_W'(OFF_DUTY_LO) && addr_i != ADDR_W'(OFF_DUTY_HI) &&
     addr_i != ADDR_W'(OFF_CTRL) && addr_i != ADDR_W'(OFF_TBSEL))
    |=> ($stable(duty_q) && $stable(hi_stage_q) && $stable(ctrl_q) && $stable(sel_q)));

endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp #(
  parameter int NUM_TB = 4,
  parameter int CNT_W  = 10,
  parameter int DUTY_W = 10,
  parameter int SEL_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_TB*CNT_W-1:0] tb_cnt_i,
  input  logic [NUM_TB-1:0]       tb_sop_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [DUTY_W-1:0]       duty_i,
  input  logic                    gate_i,
  output logic                    lvl_o
);

  logic [CNT_W-1:0]  cnt_arr [NUM_TB];
  logic [CNT_W-1:0]  cnt_sel;
  logic              sop_sel;
  logic [DUTY_W-1:0] duty_act_q;
  logic [DUTY_W-1:0] duty_use;
  logic              load;
  logic              lvl_q;

  for (genvar k = 0; k < NUM_TB; k++) begin : g_tb
    assign cnt_arr[k] = tb_cnt_i[k*CNT_W +: CNT_W];
  end

  assign cnt_sel = cnt_arr[sel_i];
  assign sop_sel = tb_sop_i[sel_i];

  // gated: track working duty so ungating starts with the fresh value
  assign load     = gate_i || sop_sel;
  assign duty_use = load ? duty_i : duty_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_act_q <= '0;
      lvl_q      <= 1'b0;
    end else begin
      duty_act_q <= duty_use;
      lvl_q      <= !gate_i && ({{(DUTY_W > CNT_W ? DUTY_W-CNT_W : 0){1'b0}}, cnt_sel} < duty_use);
    end
  end

  assign lvl_o = lvl_q;

  // R5
  commit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sop_sel && !gate_i) |=> (duty_act_q == $past(duty_act_q)));

  // R7
  gate_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |=> !lvl_q);

  // R4
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act_q == '0 && !sop_sel) |=> !lvl_q);

endmodule

// File: rtl/pwm_chan_drv.sv
module pwm_chan_drv (
  input  logic lvl_i,
  input  logic inv_i,
  input  logic od_i,
  output logic pwm_o,
  output logic oe_o
);

  logic logic_lvl;

  assign logic_lvl = lvl_i ^ inv_i;

  // open-drain: drive low for 0, release for 1
  always_comb begin
    if (od_i) begin
      pwm_o = 1'b0;
      oe_o  = !logic_lvl;
    end else begin
      pwm_o = logic_lvl;
      oe_o  = 1'b1;
    end
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int NUM_TB = 4,
  parameter int CNT_W  = 10,
  parameter int DUTY_W = 10,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  input  logic [NUM_TB*CNT_W-1:0] tb_cnt_i,
  input  logic [NUM_TB-1:0]       tb_sop_i,
  output logic                    pwm_o,
  output logic                    pwm_oe_o
);

  localparam int SEL_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1;

  logic [DUTY_W-1:0] duty;
  ctrl_t             ctrl;
  logic [SEL_W-1:0]  sel;
  logic              lvl;

  pwm_chan_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUTY_W(DUTY_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .duty_o (duty),
    .ctrl_o (ctrl),
    .sel_o  (sel)
  );

  pwm_chan_cmp #(
    .NUM_TB(NUM_TB), .CNT_W(CNT_W), .DUTY_W(DUTY_W), .SEL_W(SEL_W)
  ) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tb_cnt_i(tb_cnt_i),
    .tb_sop_i(tb_sop_i),
    .sel_i   (sel),
    .duty_i  (duty),
    .gate_i  (ctrl.clk_gate),
    .lvl_o   (lvl)
  );

  pwm_chan_drv u_drv (
    .lvl_i(lvl),
    .inv_i(ctrl.pol_inv),
    .od_i (ctrl.od_en),
    .pwm_o(pwm_o),
    .oe_o (pwm_oe_o)
  );

  // R8
  gated_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl.clk_gate) && ctrl.clk_gate && !ctrl.od_en) |-> (pwm_o == ctrl.pol_inv));

  // R9
  od_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl.clk_gate) && ctrl.clk_gate && ctrl.od_en) |-> (pwm_oe_o == !ctrl.pol_inv));

endmodule

// File: tb/pwm_chan_tb.sv
`timescale 1ns/1ps
module pwm_chan_tb;
  localparam int NUM_TB = 4;
  localparam int CNT_W  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                    reg_we = 1'b0;
  logic [3:0]              reg_addr = '0;
  logic [7:0]              reg_wdata = '0;
  logic [7:0]              reg_rdata;
  logic [NUM_TB*CNT_W-1:0] tb_cnt = '0;
  logic [NUM_TB-1:0]       tb_sop = '0;
  logic                    pwm, pwm_oe;

  pwm_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .tb_cnt_i(tb_cnt),
    .tb_sop_i(tb_sop), .pwm_o(pwm), .pwm_oe_o(pwm_oe)
  );

  int vecs = 0, errs = 0;
  int tb_c [NUM_TB] = '{0, 0, 0, 0};
  int tb_len [NUM_TB] = '{15, 40, 99, 7};
  int hi_cnt, oe_cnt;

  logic [9:0] m_duty, m_act;
  logic [1:0] m_hi, m_sel;
  logic [2:0] m_ctrl;
  logic       m_lvl;

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_duty[7:0];
      4'd1: return {6'b0, m_hi};
      4'd4: return {5'b0, m_ctrl};
      4'd5: return {6'b0, m_sel};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  task automatic step(input bit we, input logic [3:0] a, input logic [7:0] d,
                      input bit rd, input string tag);
    int s;
    logic [9:0] c, use_d;
    logic g, lg, exp_o, exp_oe;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    for (int k = 0; k < NUM_TB; k++) begin
      tb_cnt[k*CNT_W +: CNT_W] = CNT_W'(tb_c[k]);
      tb_sop[k] = (tb_c[k] == 0);
      tb_c[k] = (tb_c[k] == tb_len[k]) ? 0 : tb_c[k] + 1;
    end
    #1;
    if (rd && !we) chk(reg_rdata == m_read(a), {tag, " read"}, reg_rdata, m_read(a));
    @(posedge clk);
    s = int'(m_sel);
    c = tb_cnt[s*CNT_W +: CNT_W];
    g = m_ctrl[1];
    use_d = (g || tb_sop[s]) ? m_duty : m_act;
    m_lvl = !g && (c < use_d);
    m_act = use_d;
    if (we) begin
      case (a)
        4'd0: m_duty = {m_hi, d};
        4'd1: m_hi = d[1:0];
        4'd4: m_ctrl = d[2:0];
        4'd5: m_sel = d[1:0];
        default: ;
      endcase
    end
    #1;
    lg = m_lvl ^ m_ctrl[0];
    exp_o  = m_ctrl[2] ? 1'b0 : lg;
    exp_oe = m_ctrl[2] ? !lg : 1'b1;
    chk(pwm == exp_o && pwm_oe == exp_oe, tag, {pwm, pwm_oe}, {exp_o, exp_oe});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 8'd0, 1'b0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    step(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b0, a, 8'd0, 1'b1, tag);
  endtask

  task automatic window(input int n, input string tag);
    hi_cnt = 0; oe_cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, 4'd0, 8'd0, 1'b0, tag);
      hi_cnt += int'(pwm);
      oe_cnt += int'(pwm_oe);
    end
  endtask

  initial begin
    #(4ns * 200000);
    vecs++; errs++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    m_duty = '0; m_act = '0; m_hi = '0; m_sel = '0; m_ctrl = 3'b010; m_lvl = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #0.5;
    chk(pwm == 1'b0 && pwm_oe == 1'b1, "R1 pins", {pwm, pwm_oe}, 2'b01);
    rd(4'd4, "R1 ctrl");
    chk(reg_rdata == 8'h02, "R1 ctrl lit", reg_rdata, 8'h02);
    rd(4'd0, "R1 duty lo");
    rd(4'd1, "R1 duty hi");
    rd(4'd5, "R1 sel");

    // R4 basic duty on timebase 0 (period 16)
    wr(4'd0, 8'h05, "R4 wr");
    wr(4'd4, 8'h00, "R4 ungate");
    idle(20, "R4 settle");
    window(32, "R4 win");
    chk(hi_cnt == 10, "R4 duty5 count", hi_cnt, 10);

    // R3 staged high byte
    wr(4'd1, 8'h01, "R3 stage");
    rd(4'd1, "R3 stage read");
    rd(4'd0, "R3 lo read");
    idle(20, "R3 settle");
    window(32, "R3 win");
    chk(hi_cnt == 10, "R3 staged no effect", hi_cnt, 10);
    wr(4'd0, 8'h00, "R3 commit");
    idle(20, "R4 settle2");
    window(32, "R4 big");
    chk(hi_cnt == 32, "R4 duty over length", hi_cnt, 32);

    // R5 commit waits for strobe (model checks each cycle)
    wr(4'd1, 8'h00, "R5 hi0");
    wr(4'd0, 8'h00, "R5 lo0");
    idle(20, "R5 wait");
    window(32, "R4 zero");
    chk(hi_cnt == 0, "R4 duty zero", hi_cnt, 0);

    // R6 timebase select: unit 3, period 8
    wr(4'd5, 8'h03, "R6 sel");
    wr(4'd0, 8'h02, "R6 duty");
    idle(20, "R6 settle");
    window(32, "R6 win");
    chk(hi_cnt == 8, "R6 sel3 count", hi_cnt, 8);

    // R8 invert
    wr(4'd4, 8'h01, "R8 inv");
    idle(4, "R8 settle");
    window(32, "R8 win");
    chk(hi_cnt == 24, "R8 inv count", hi_cnt, 24);

    // R7 gating
    wr(4'd4, 8'h03, "R7 gate inv");
    idle(2, "R7 settle");
    window(16, "R7 win inv");
    chk(hi_cnt == 16, "R7 gated inv rest", hi_cnt, 16);
    wr(4'd4, 8'h02, "R7 gate");
    idle(2, "R7 settle2");
    window(16, "R7 win");
    chk(hi_cnt == 0, "R7 gated rest", hi_cnt, 0);

    // R9 open-drain
    wr(4'd4, 8'h04, "R9 od");
    idle(20, "R9 settle");
    window(32, "R9 win");
    chk(hi_cnt == 0, "R9 pin low", hi_cnt, 0);
    chk(oe_cnt == 24, "R9 oe released", oe_cnt, 24);

    // R2 stray offsets ignored
    wr(4'd2, 8'hff, "R2 off2");
    wr(4'd7, 8'hff, "R2 off7");
    wr(4'd15, 8'hff, "R2 offF");
    rd(4'd0, "R2 lo");
    rd(4'd1, "R2 hi");
    rd(4'd4, "R2 ctrl");
    rd(4'd5, "R2 sel");
    rd(4'd3, "R2 hole");
    chk(reg_rdata == 8'h00 && m_ctrl == 3'b100, "R2 lit", reg_rdata, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] a;
      r = int'($urandom_range(0, 15));
      case ($urandom_range(0, 5))
        0: a = 4'd0; 1: a = 4'd1; 2: a = 4'd4; 3: a = 4'd5; 4: a = 4'd0;
        default: a = 4'($urandom_range(0, 15));
      endcase
      if (a == 4'd4 && ($urandom_range(0, 3) != 0)) a = 4'd0;
      if (r == 0) wr(a, 8'($urandom()), "R5 rand wr");
      else if (r == 1) rd(a, "R2 rand rd");
      else idle(1, "R4 rand");
    end

    summary();
    $finish;
  end

endmodule